// File: doc/BRIEF.md
# Threaded Store Queue with Load Forwarding

This block holds stores that have left the pipeline but are not yet in the memory system. Several hardware threads share it. One array is split into equal slices, one slice per thread, and each slice works as its own first-in first-out queue. A store is written into its thread's slice without any cache lookup. Each store carries an address, a data word, a byte mask and an ordering kind, which is strict or relaxed.

The queue drains through a registered valid/ready request port. One request leaves per cycle, and the threads take turns. A strict store may issue only when no other strict store of the same thread is still waiting for its acknowledge. Relaxed stores have no such limit. The memory side returns an acknowledge tagged with a thread number. That acknowledge retires the thread's oldest issued store and produces a one-cycle write strobe toward the first-level data cache. The cache therefore never sees a store before its acknowledge, and a store never allocates a line.

A load probes its own thread's slice. If the youngest overlapping store covers every byte the load asks for, its data is forwarded. If that store covers only some of the bytes, the load is told to stall.

Top module: `store_fwd_buf`

## Requirements
- R1: After reset, every slice is empty: `req_valid`, `dc_wr_valid`, `ld_hit`, `ld_stall` and all bits of `st_full` are 0.
- R2: Each thread holds at most DEPTH stores. `st_full[t]` is 1 exactly when thread t holds DEPTH stores. A store offered to a full thread is discarded, and stores of other threads are still accepted.
- R3: Within a thread, stores leave in arrival order. Each request carries the entry's address, data, mask and kind (`req_relaxed`=1 for relaxed). While `req_valid` is high and `req_ready` is low, the request and its payload stay unchanged.
- R4: Strict stores (`st_relaxed`=0) are limited to one per thread that has been issued and not yet acknowledged. A later strict store of that thread waits for the acknowledge.
- R5: Relaxed stores (`st_relaxed`=1) have no in-flight limit: all DEPTH entries of a thread may be issued before any acknowledge.
- R6: `ack_valid` with `ack_tid`=t retires thread t's oldest issued entry. In the next cycle `dc_wr_valid` is 1 with that entry's address, data and mask. An acknowledge for a thread with no issued entry is ignored: no write strobe and no change to the thread's contents.
- R7: A load (`ld_valid`) is answered in the next cycle. Consider the youngest entry of the same thread, issued or not, that is not yet acknowledged, has an equal address and has a mask overlapping `ld_mask`. If that entry's mask covers every bit of `ld_mask`, `ld_hit` is 1 and `ld_data` is that entry's data word. Mask bit i covers data bits 8i+7..8i.
- R8: If that youngest overlapping entry lacks any byte of `ld_mask`, `ld_stall` is 1 and `ld_hit` is 0.
- R9: If no entry of the load's own thread overlaps, both `ld_hit` and `ld_stall` are 0. Entries of other threads never match.
- R10: Issue among threads with an issuable entry is round-robin, starting from the thread after the one granted last. Thread 0 is first after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_tid | input | $clog2(NTHR) | Thread of the store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_mask | input | DW/8 | Store byte mask |
| st_relaxed | input | 1 | 1 = relaxed order, 0 = strict order |
| st_full | output | NTHR | Per-thread slice full |
| ld_valid | input | 1 | Load probe |
| ld_tid | input | $clog2(NTHR) | Thread of the load |
| ld_addr | input | AW | Load word address |
| ld_mask | input | DW/8 | Load byte mask |
| ld_hit | output | 1 | Forwarded data valid (next cycle) |
| ld_stall | output | 1 | Partial overlap, load must wait |
| ld_data | output | DW | Forwarded data |
| req_valid | output | 1 | Drain request valid |
| req_ready | input | 1 | Memory side takes the request |
| req_tid | output | $clog2(NTHR) | Thread of the request |
| req_addr | output | AW | Request address |
| req_data | output | DW | Request data |
| req_mask | output | DW/8 | Request byte mask |
| req_relaxed | output | 1 | Ordering kind of the request |
| ack_valid | input | 1 | Acknowledge from memory side |
| ack_tid | input | $clog2(NTHR) | Thread being acknowledged |
| dc_wr_valid | output | 1 | Data cache write strobe |
| dc_wr_addr | output | AW | Data cache write address |
| dc_wr_data | output | DW | Data cache write data |
| dc_wr_mask | output | DW/8 | Data cache write byte mask |

## Verification
The bench builds the block with four threads, a slice depth of four, a three-bit address and a 32-bit word. With a depth that small, every slice fills within a few stores, so the full and discard path and the wrap of all pointers come up thousands of times. With only eight distinct addresses, loads often meet several same-address stores of one thread, which makes the youngest-match choice, full coverage and partial coverage frequent. The directed part pins down the exact round-robin order, the single strict store in flight, and a full slice of relaxed stores in flight together.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  typedef enum logic {ORD_STRICT = 1'b0, ORD_RELAXED = 1'b1} ord_e;
endpackage

// File: rtl/sfb_slice.sv
// Per-thread pointer and occupancy control for one slice of the store array.
module sfb_slice #(
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          issue,
  input  logic          issue_strict,
  input  logic          ack,
  input  logic          head_strict,
  output logic [PW-1:0] head,
  output logic [PW-1:0] sendp,
  output logic [PW-1:0] tailp,
  output logic [CW-1:0] count,
  output logic [CW-1:0] nsent,
  output logic          sbusy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      sendp <= '0;
      tailp <= '0;
      count <= '0;
      nsent <= '0;
      sbusy <= 1'b0;
    end else begin
      if (push)  tailp <= tailp + PW'(1);
      if (issue) sendp <= sendp + PW'(1);
      if (ack)   head  <= head + PW'(1);
      count <= count + CW'(push) - CW'(ack);
      nsent <= nsent + CW'(issue) - CW'(ack);
      sbusy <= (sbusy && !(ack && head_strict)) || (issue && issue_strict);
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r3_sent_within_held: assert property (@(posedge clk) disable iff (rst)
    nsent <= count);
  a_r4_one_strict: assert property (@(posedge clk) disable iff (rst)
    sbusy |-> !(issue && issue_strict));
  a_r6_ack_has_issued: assert property (@(posedge clk) disable iff (rst)
    ack |-> (nsent != '0));
endmodule

// File: rtl/sfb_rr.sv
// Round-robin pick among threads with an issuable entry.
module sfb_rr #(
  parameter int N  = 4,
  parameter int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  elig,
  input  logic          adv,
  output logic [TW-1:0] gnt,
  output logic          any
);
  logic [TW-1:0] last;

  always_comb begin
    any = |elig;
    gnt = last;
    for (int k = N; k >= 1; k--) begin
      if (elig[(int'(last) + k) % N]) gnt = TW'((int'(last) + k) % N);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             last <= TW'(N - 1);
    else if (adv && any) last <= gnt;
  end

  a_r10_grant_eligible: assert property (@(posedge clk) disable iff (rst)
    (adv && any) |-> elig[gnt]);
endmodule

// File: rtl/sfb_fwd.sv
// Youngest-match search over one thread's slice for load forwarding.
module sfb_fwd #(
  parameter int DEPTH = 8,
  parameter int AW    = 40,
  parameter int DW    = 64,
  parameter int BW    = DW / 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic [PW-1:0]                head,
  input  logic [PW:0]                  count,
  input  logic [AW-1:0]                addr,
  input  logic [BW-1:0]                mask,
  input  logic [DEPTH-1:0][AW-1:0]     ea,
  input  logic [DEPTH-1:0][DW-1:0]     ed,
  input  logic [DEPTH-1:0][BW-1:0]     em,
  output logic                         hit,
  output logic                         stall,
  output logic [DW-1:0]                data
);
  logic          found;
  logic [BW-1:0] fmask;
  logic [PW-1:0] slot;

  always_comb begin
    found = 1'b0;
    fmask = '0;
    data  = '0;
    slot  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head + PW'(k);
      if ((PW + 1)'(k) < count && ea[slot] == addr && |(em[slot] & mask)) begin
        found = 1'b1;
        fmask = em[slot];
        data  = ed[slot];
      end
    end
    hit   = found && ((mask & ~fmask) == '0);
    stall = found && !hit;
  end
endmodule

// File: rtl/store_fwd_buf.sv
module store_fwd_buf
  import sfb_pkg::*;
#(
  parameter int NTHR  = 4,
  parameter int DEPTH = 8,
  parameter int AW    = 40,
  parameter int DW    = 64,
  parameter int BW    = DW / 8,
  parameter int TW    = $clog2(NTHR),
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_valid,
  input  logic [TW-1:0]   st_tid,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [BW-1:0]   st_mask,
  input  logic            st_relaxed,
  output logic [NTHR-1:0] st_full,
  input  logic            ld_valid,
  input  logic [TW-1:0]   ld_tid,
  input  logic [AW-1:0]   ld_addr,
  input  logic [BW-1:0]   ld_mask,
  output logic            ld_hit,
  output logic            ld_stall,
  output logic [DW-1:0]   ld_data,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [TW-1:0]   req_tid,
  output logic [AW-1:0]   req_addr,
  output logic [DW-1:0]   req_data,
  output logic [BW-1:0]   req_mask,
  output logic            req_relaxed,
  input  logic            ack_valid,
  input  logic [TW-1:0]   ack_tid,
  output logic            dc_wr_valid,
  output logic [AW-1:0]   dc_wr_addr,
  output logic [DW-1:0]   dc_wr_data,
  output logic [BW-1:0]   dc_wr_mask
);
  // Slice depth must be a power of two: entry index = {thread, pointer}.
  localparam int NENT = NTHR * DEPTH;
  localparam int IW   = TW + PW;
  localparam int CW   = PW + 1;

  // Unified entry array, written one entry per cycle.
  logic [AW-1:0] e_addr [NENT];
  logic [DW-1:0] e_data [NENT];
  logic [BW-1:0] e_mask [NENT];
  ord_e          e_ord  [NENT];

  logic [PW-1:0] head  [NTHR];
  logic [PW-1:0] sendp [NTHR];
  logic [PW-1:0] tailp [NTHR];
  logic [CW-1:0] count [NTHR];
  logic [CW-1:0] nsent [NTHR];
  logic [NTHR-1:0] sbusy, elig, push_v, issue_v, ack_v;

  logic          load_reg, any, ack_ok, st_acc;
  logic [TW-1:0] gnt;
  logic [IW-1:0] widx, gidx, hidx;

  assign st_acc   = st_valid && !st_full[st_tid];
  assign widx     = {st_tid, tailp[st_tid]};
  assign gidx     = {gnt, sendp[gnt]};
  assign hidx     = {ack_tid, head[ack_tid]};
  assign load_reg = !req_valid || req_ready;
  assign ack_ok   = ack_valid && (nsent[ack_tid] != '0);

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [IW-1:0] sidx, hix;
    assign sidx       = {TW'(t), sendp[t]};
    assign hix        = {TW'(t), head[t]};
    assign st_full[t] = (count[t] == CW'(DEPTH));
    assign push_v[t]  = st_acc && (st_tid == TW'(t));
    assign elig[t]    = (nsent[t] < count[t]) &&
                        (e_ord[sidx] == ORD_RELAXED || !sbusy[t]);
    assign issue_v[t] = load_reg && any && (gnt == TW'(t));
    assign ack_v[t]   = ack_ok && (ack_tid == TW'(t));

    sfb_slice #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_slice (
      .clk          (clk),
      .rst          (rst),
      .push         (push_v[t]),
      .issue        (issue_v[t]),
      .issue_strict (e_ord[sidx] == ORD_STRICT),
      .ack          (ack_v[t]),
      .head_strict  (e_ord[hix] == ORD_STRICT),
      .head         (head[t]),
      .sendp        (sendp[t]),
      .tailp        (tailp[t]),
      .count        (count[t]),
      .nsent        (nsent[t]),
      .sbusy        (sbusy[t])
    );
  end

  sfb_rr #(.N(NTHR), .TW(TW)) u_rr (
    .clk  (clk),
    .rst  (rst),
    .elig (elig),
    .adv  (load_reg),
    .gnt  (gnt),
    .any  (any)
  );

  // Entry write: no lookup of any cache state on insert.
  always_ff @(posedge clk) begin
    if (st_acc) begin
      e_addr[widx] <= st_addr;
      e_data[widx] <= st_data;
      e_mask[widx] <= st_mask;
      e_ord[widx]  <= st_relaxed ? ORD_RELAXED : ORD_STRICT;
    end
  end

  // Load forwarding over the load's own slice.
  logic [DEPTH-1:0][AW-1:0] fa;
  logic [DEPTH-1:0][DW-1:0] fd;
  logic [DEPTH-1:0][BW-1:0] fm;
  logic          f_hit, f_stall;
  logic [DW-1:0] f_data;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      fa[j] = e_addr[{ld_tid, PW'(j)}];
      fd[j] = e_data[{ld_tid, PW'(j)}];
      fm[j] = e_mask[{ld_tid, PW'(j)}];
    end
  end

  sfb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BW(BW), .PW(PW)) u_fwd (
    .head  (head[ld_tid]),
    .count (count[ld_tid]),
    .addr  (ld_addr),
    .mask  (ld_mask),
    .ea    (fa),
    .ed    (fd),
    .em    (fm),
    .hit   (f_hit),
    .stall (f_stall),
    .data  (f_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_hit   <= 1'b0;
      ld_stall <= 1'b0;
    end else begin
      ld_hit   <= ld_valid && f_hit;
      ld_stall <= ld_valid && f_stall;
    end
    if (ld_valid) ld_data <= f_data;
  end

  // Registered drain request stage.
  always_ff @(posedge clk) begin
    if (rst)           req_valid <= 1'b0;
    else if (load_reg) req_valid <= any;
    if (load_reg && any) begin
      req_tid     <= gnt;
      req_addr    <= e_addr[gidx];
      req_data    <= e_data[gidx];
      req_mask    <= e_mask[gidx];
      req_relaxed <= (e_ord[gidx] == ORD_RELAXED);
    end
  end

  // Cache write only after the acknowledge.
  always_ff @(posedge clk) begin
    if (rst) dc_wr_valid <= 1'b0;
    else     dc_wr_valid <= ack_ok;
    if (ack_ok) begin
      dc_wr_addr <= e_addr[hidx];
      dc_wr_data <= e_data[hidx];
      dc_wr_mask <= e_mask[hidx];
    end
  end

  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_tid) &&
      $stable(req_addr) && $stable(req_data) && $stable(req_mask) && $stable(req_relaxed)));
  a_r10_one_issue: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue_v));
  a_r6_write_after_ack: assert property (@(posedge clk) disable iff (rst)
    ack_ok |=> dc_wr_valid);
  a_r8_hit_stall_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ld_hit && ld_stall));
  a_r2_full_drop: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_full[st_tid]) |-> !(|push_v));
endmodule

// File: tb/sim_store_fwd_buf.sv
module sim_store_fwd_buf;
  localparam int CLK_NS = 10;
  localparam int NT = 4;
  localparam int DP = 4;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst;
  always #(CLK_NS / 2) clk = ~clk;

  logic st_valid, st_relaxed, ld_valid, req_ready, ack_valid;
  logic [TW-1:0] st_tid, ld_tid, ack_tid;
  logic [AW-1:0] st_addr, ld_addr;
  logic [DW-1:0] st_data;
  logic [BW-1:0] st_mask, ld_mask;
  logic [NT-1:0] st_full;
  logic ld_hit, ld_stall, req_valid, req_relaxed, dc_wr_valid;
  logic [DW-1:0] ld_data, req_data, dc_wr_data;
  logic [TW-1:0] req_tid;
  logic [AW-1:0] req_addr, dc_wr_addr;
  logic [BW-1:0] req_mask, dc_wr_mask;

  store_fwd_buf #(.NTHR(NT), .DEPTH(DP), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_tid(st_tid), .st_addr(st_addr), .st_data(st_data),
    .st_mask(st_mask), .st_relaxed(st_relaxed), .st_full(st_full),
    .ld_valid(ld_valid), .ld_tid(ld_tid), .ld_addr(ld_addr), .ld_mask(ld_mask),
    .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_tid(req_tid),
    .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask),
    .req_relaxed(req_relaxed),
    .ack_valid(ack_valid), .ack_tid(ack_tid),
    .dc_wr_valid(dc_wr_valid), .dc_wr_addr(dc_wr_addr),
    .dc_wr_data(dc_wr_data), .dc_wr_mask(dc_wr_mask)
  );

  int errors = 0;
  int checks = 0;

  // Reference model of each thread's queue, index 0 = oldest.
  logic [AW-1:0] m_a [NT][DP];
  logic [DW-1:0] m_d [NT][DP];
  logic [BW-1:0] m_m [NT][DP];
  logic          m_r [NT][DP];
  int m_cnt [NT];
  int m_sent [NT];
  bit m_busy [NT];
  int hs_n;
  int hs_tid [64];
  int hs_per [NT];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    st_valid = 0; st_tid = '0; st_addr = '0; st_data = '0; st_mask = '0; st_relaxed = 0;
    ld_valid = 0; ld_tid = '0; ld_addr = '0; ld_mask = '0;
    ack_valid = 0; ack_tid = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    req_ready = 0;
    rst = 1;
    for (int t = 0; t < NT; t++) begin
      m_cnt[t] = 0; m_sent[t] = 0; m_busy[t] = 0; hs_per[t] = 0;
    end
    hs_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  // One clock: predict from the model, take the edge, compare, update.
  task automatic step();
    bit e_hit, e_stall, found, lchk, dexp, do_push;
    logic [DW-1:0] e_data, fdat, dd;
    logic [BW-1:0] fmsk, dm;
    logic [AW-1:0] da;
    logic [NT-1:0] efull;
    int t, at, pt;
    string ltag;
    lchk = ld_valid; e_hit = 0; e_stall = 0; e_data = '0; found = 0;
    fdat = '0; fmsk = '0;
    if (ld_valid) begin
      for (int k = 0; k < m_cnt[ld_tid]; k++) begin
        if (m_a[ld_tid][k] == ld_addr && (m_m[ld_tid][k] & ld_mask) != '0) begin
          found = 1; fdat = m_d[ld_tid][k]; fmsk = m_m[ld_tid][k];
        end
      end
      if (found) begin
        if ((ld_mask & ~fmsk) == '0) begin e_hit = 1; e_data = fdat; end
        else e_stall = 1;
      end
    end
    if (req_valid && req_ready) begin
      t = int'(req_tid);
      chk(m_sent[t] < m_cnt[t], "R3 request from thread with nothing pending", 64'(m_sent[t]), 64'(m_cnt[t]));
      if (m_sent[t] < m_cnt[t]) begin
        chk(req_addr == m_a[t][m_sent[t]], "R3 drain order address", 64'(req_addr), 64'(m_a[t][m_sent[t]]));
        chk(req_data == m_d[t][m_sent[t]], "R3 drain order data", 64'(req_data), 64'(m_d[t][m_sent[t]]));
        chk(req_relaxed == m_r[t][m_sent[t]], "R3 drain kind", 64'(req_relaxed), 64'(m_r[t][m_sent[t]]));
        if (!req_relaxed) begin
          chk(!m_busy[t], "R4 second strict store in flight", 64'(1), 64'(0));
          m_busy[t] = 1;
        end
        m_sent[t]++;
      end
      if (hs_n < 64) hs_tid[hs_n] = t;
      hs_n++;
      hs_per[t]++;
    end
    at = int'(ack_tid);
    dexp = ack_valid && m_sent[at] > 0;
    da = m_a[at][0]; dd = m_d[at][0]; dm = m_m[at][0];
    pt = int'(st_tid);
    do_push = st_valid && m_cnt[pt] < DP;
    @(posedge clk);
    @(negedge clk);
    if (dexp) begin
      if (!m_r[at][0]) m_busy[at] = 0;
      for (int k = 0; k < DP - 1; k++) begin
        m_a[at][k] = m_a[at][k+1]; m_d[at][k] = m_d[at][k+1];
        m_m[at][k] = m_m[at][k+1]; m_r[at][k] = m_r[at][k+1];
      end
      m_cnt[at]--; m_sent[at]--;
    end
    if (do_push) begin
      m_a[pt][m_cnt[pt]] = st_addr; m_d[pt][m_cnt[pt]] = st_data;
      m_m[pt][m_cnt[pt]] = st_mask; m_r[pt][m_cnt[pt]] = st_relaxed;
      m_cnt[pt]++;
    end
    if (lchk) begin
      ltag = e_hit ? "R7 load hit flag" : (e_stall ? "R8 load partial overlap" : "R9 load miss");
      chk(ld_hit == e_hit, ltag, 64'(ld_hit), 64'(e_hit));
      chk(ld_stall == e_stall, ltag, 64'(ld_stall), 64'(e_stall));
      if (e_hit) chk(ld_data == e_data, "R7 forwarded data", 64'(ld_data), 64'(e_data));
    end
    chk(dc_wr_valid == dexp, "R6 cache write strobe", 64'(dc_wr_valid), 64'(dexp));
    if (dexp) begin
      chk(dc_wr_addr == da, "R6 cache write address", 64'(dc_wr_addr), 64'(da));
      chk(dc_wr_data == dd, "R6 cache write data", 64'(dc_wr_data), 64'(dd));
      chk(dc_wr_mask == dm, "R6 cache write mask", 64'(dc_wr_mask), 64'(dm));
    end
    for (int k = 0; k < NT; k++) efull[k] = (m_cnt[k] == DP);
    chk(st_full == efull, "R2 full flags", 64'(st_full), 64'(efull));
    idle_inputs();
  endtask

  task automatic put(input int t, input int a, input logic [DW-1:0] d, input int m, input bit r);
    st_valid = 1; st_tid = TW'(t); st_addr = AW'(a); st_data = d; st_mask = BW'(m); st_relaxed = r;
    step();
  endtask

  task automatic probe(input int t, input int a, input int m);
    ld_valid = 1; ld_tid = TW'(t); ld_addr = AW'(a); ld_mask = BW'(m);
    step();
  endtask

  task automatic drain_all();
    bit busy;
    for (int n = 0; n < 200; n++) begin
      busy = 0;
      for (int t = 0; t < NT; t++) if (m_cnt[t] > 0) busy = 1;
      if (!busy) break;
      req_ready = 1;
      for (int t = NT - 1; t >= 0; t--) begin
        if (m_sent[t] > 0) begin ack_valid = 1; ack_tid = TW'(t); end
      end
      step();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: state right after reset
    do_reset();
    chk(req_valid == 0, "R1 req_valid after reset", 64'(req_valid), 64'(0));
    chk(dc_wr_valid == 0, "R1 dc_wr_valid after reset", 64'(dc_wr_valid), 64'(0));
    chk(ld_hit == 0 && ld_stall == 0, "R1 load flags after reset", 64'({ld_hit, ld_stall}), 64'(0));
    chk(st_full == '0, "R1 full flags after reset", 64'(st_full), 64'(0));
    probe(0, 0, 15);

    // R10: round-robin order 0,1,2,0,1,2
    do_reset();
    put(0, 1, 32'h100, 15, 1);
    put(0, 2, 32'h101, 15, 1);
    put(1, 3, 32'h110, 15, 1);
    put(1, 4, 32'h111, 15, 1);
    put(2, 5, 32'h120, 15, 1);
    put(2, 6, 32'h121, 15, 1);
    req_ready = 1;
    repeat (8) step();
    chk(hs_n == 6, "R10 request count", 64'(hs_n), 64'(6));
    for (int i = 0; i < 6; i++)
      chk(hs_tid[i] == i % 3, "R10 round-robin order", 64'(hs_tid[i]), 64'(i % 3));
    drain_all();

    // R4: two strict stores of one thread, one in flight until the ack
    do_reset();
    put(3, 1, 32'hA1, 15, 0);
    put(3, 2, 32'hA2, 15, 0);
    req_ready = 1;
    repeat (8) step();
    chk(hs_per[3] == 1, "R4 strict issues before ack", 64'(hs_per[3]), 64'(1));
    ack_valid = 1; ack_tid = 2'd3;
    step();
    repeat (4) step();
    chk(hs_per[3] == 2, "R4 strict issues after ack", 64'(hs_per[3]), 64'(2));
    // R6: acknowledge to a thread with nothing issued is ignored
    ack_valid = 1; ack_tid = 2'd0;
    step();
    drain_all();

    // R5 and R2: a full slice of relaxed stores all in flight, overflow dropped
    do_reset();
    req_ready = 1;
    for (int i = 0; i < DP; i++) put(2, i, 32'hB0 + i, 15, 1);
    put(2, 7, 32'hDEAD, 15, 1);
    put(1, 7, 32'hC0, 15, 1);
    repeat (10) step();
    chk(hs_per[2] == DP, "R5 relaxed stores in flight", 64'(hs_per[2]), 64'(DP));
    drain_all();

    // R7, R8, R9: youngest match, partial coverage, other thread
    do_reset();
    put(1, 5, 32'h11111111, 4'b0011, 1);
    put(1, 5, 32'h22222222, 4'b1111, 1);
    probe(1, 5, 4'b0001);
    put(1, 5, 32'h33333333, 4'b1100, 1);
    probe(1, 5, 4'b0011);
    probe(1, 5, 4'b0110);
    probe(0, 5, 4'b1111);
    probe(1, 2, 4'b1111);
    drain_all();

    // Random sweep over all of the above
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      int at;
      st_valid = ($urandom % 3) != 0;
      st_tid = TW'($urandom); st_addr = AW'($urandom); st_data = $urandom;
      st_mask = BW'($urandom); if (st_mask == '0) st_mask = 4'b0001;
      st_relaxed = 1'($urandom);
      ld_valid = 1'($urandom);
      ld_tid = TW'($urandom); ld_addr = AW'($urandom);
      ld_mask = BW'($urandom); if (ld_mask == '0) ld_mask = 4'b1000;
      req_ready = ($urandom % 4) != 0;
      at = int'($urandom % NT);
      if (m_sent[at] > 0 && ($urandom % 2) == 1) begin
        ack_valid = 1; ack_tid = TW'(at);
      end else if (m_sent[at] == 0 && !(req_valid && int'(req_tid) == at) && ($urandom % 8) == 0) begin
        ack_valid = 1; ack_tid = TW'(at);
      end
      step();
    end
    drain_all();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule